// File: doc/BRIEF.md
# Speculative Read Tag Violation Detector

This block sits next to one processor's L1 data cache in a multiprocessor that runs loop iterations as speculative threads. It keeps one speculative-read flag and one locally-written flag per cache line entry, together with the line tag that the flags belong to. It also watches the shared write-through bus for stores from other threads. A bus store from a thread that is earlier in program order is a read-after-write hazard if this thread has already read the line speculatively. The block then raises a one-cycle violation pulse, and the thread must restart.

A small controller with four named states decides when tracking, snooping and overflow apply. ST_TRACK: loads and local stores update the flags and snoops are checked. ST_HEAD: the thread is non-speculative, so loads leave the flags alone and snoops are ignored. ST_STALL: a load or local store needed an entry that still holds a read flag for a different line. The read state cannot be kept, so the thread stalls until it becomes head, and snoops on lines already tracked are still checked. ST_VIOL: a violation has been signalled, and further snoops are ignored until the restart clear.

The transitions are as follows. Any clear (commit or restart) goes to ST_HEAD if the head input is high, and to ST_TRACK otherwise. From ST_HEAD, a falling head input goes to ST_TRACK. From ST_TRACK, a snoop hit goes to ST_VIOL; otherwise an entry conflict goes to ST_STALL; otherwise a high head input goes to ST_HEAD. From ST_STALL, a snoop hit goes to ST_VIOL; otherwise a high head input goes to ST_HEAD. ST_VIOL is left only by a clear.

Top module: `srt_violation_detector`

## Requirements
- R1: After reset, o_violation and o_overflow are low and no line is tagged, so a bus store from an earlier rank causes no violation.
- R2: A load in ST_TRACK flags entry {set, way} with its tag at the clock edge where it is presented. A later bus store whose line address {tag, set} matches, coming from a rank numerically lower than i_my_rank, makes o_violation high for exactly the one cycle after the store's edge.
- R3: A bus store whose rank is equal to or greater than i_my_rank never causes a violation, even when it matches a flagged line.
- R4: A bus store to a different tag in the same set, or to a different set, causes no violation.
- R5: A load to an entry that holds the same tag and was stored to locally does not set the read flag, so a later earlier-rank store to that line causes no violation.
- R6: While in ST_HEAD (entered one cycle after i_head rises), loads set no read flags and snoops cause no violation.
- R7: i_clr_commit and i_clr_restart each clear every flag in one cycle. A clear takes priority over a bus store presented in the same cycle.
- R8: A load to an entry that holds a read flag for a different tag raises o_overflow from the next cycle. o_overflow stays high until i_head is seen, and it drops one cycle later. The original line stays tracked meanwhile, and the conflicting line is not tracked.
- R9: After a violation, further earlier-rank stores to flagged lines cause no new pulse until a clear. After a restart clear, tracking starts again.
- R10: The read flags in different ways of one set are tracked independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_my_rank | input | RANK_W | Program-order rank of this thread (lower is earlier) |
| i_head | input | 1 | This thread is the non-speculative head |
| i_ld_valid | input | 1 | Local load completes this cycle |
| i_ld_set | input | SET_W | Set index of the load |
| i_ld_way | input | WAY_W | Way the load hit in |
| i_ld_tag | input | TAG_W | Line tag of the load |
| i_st_valid | input | 1 | Local store this cycle |
| i_st_set | input | SET_W | Set index of the store |
| i_st_way | input | WAY_W | Way of the store |
| i_st_tag | input | TAG_W | Line tag of the store |
| i_bw_valid | input | 1 | Bus store observed this cycle |
| i_bw_line | input | TAG_W+SET_W | Line address of the bus store, {tag, set} |
| i_bw_rank | input | RANK_W | Rank of the thread issuing the bus store |
| i_clr_commit | input | 1 | Clear all flags at end of iteration |
| i_clr_restart | input | 1 | Clear all flags on restart after a violation |
| o_violation | output | 1 | One-cycle violation pulse |
| o_overflow | output | 1 | Read state cannot be held; stall until head |

## Verification
A read flag that is lost or never set hides a true hazard. The only sign at the ports is that no pulse follows an earlier-rank bus store to that line, one cycle after the store's edge. A flag that stays set after a clear, or that is set while the thread is head, shows as a spurious pulse one cycle after the next matching earlier-rank store. A controller stuck in the wrong state shows either as o_overflow that does not drop one cycle after the head input, or as a second pulse without a restart clear in between. Every scenario therefore ends with a probing bus store, and its output is sampled on the cycle right after that store.

// File: rtl/srt_pkg.sv
`timescale 1ns/1ps
package srt_pkg;
    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_HEAD  = 2'd1,
        ST_STALL = 2'd2,
        ST_VIOL  = 2'd3
    } trk_state_e;
endpackage

// File: rtl/srt_tag_array.sv
`timescale 1ns/1ps
module srt_tag_array #(
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_all,
    input  logic                    upd_en,
    input  logic                    ld_v,
    input  logic [SET_W-1:0]        ld_set,
    input  logic [WAY_W-1:0]        ld_way,
    input  logic [TAG_W-1:0]        ld_tag,
    input  logic                    st_v,
    input  logic [SET_W-1:0]        st_set,
    input  logic [WAY_W-1:0]        st_way,
    input  logic [TAG_W-1:0]        st_tag,
    input  logic [SET_W-1:0]        snp_set,
    output logic                    conflict,
    output logic [WAYS-1:0]         snp_rd,
    output logic [WAYS*TAG_W-1:0]   snp_tag
);
    localparam int ENTRIES = SETS * WAYS;
    localparam int IDX_W   = SET_W + WAY_W;

    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] rd_q;
    logic [ENTRIES-1:0] wr_q;

    logic [IDX_W-1:0] li, si;
    logic ld_same, st_same, ld_conf, st_conf;
    logic ld_alloc, ld_do, st_alloc, st_mark;

    always_comb begin
        li       = {ld_set, ld_way};
        si       = {st_set, st_way};
        ld_same  = (tag_q[li] == ld_tag);
        st_same  = (tag_q[si] == st_tag);
        ld_conf  = ld_v && rd_q[li] && !ld_same;
        st_conf  = st_v && rd_q[si] && !st_same;
        conflict = ld_conf || st_conf;
        // a load allocates unless the entry already holds its line or a foreign read
        ld_do    = upd_en && ld_v && !ld_conf;
        ld_alloc = ld_do && !(ld_same && (rd_q[li] || wr_q[li]));
        st_mark  = upd_en && st_v && !st_conf;
        st_alloc = st_mark && !(st_same && (rd_q[si] || wr_q[si]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
            wr_q <= '0;
        end else if (clr_all) begin
            rd_q <= '0;
            wr_q <= '0;
        end else begin
            if (ld_alloc) begin
                rd_q[li] <= 1'b1;
                wr_q[li] <= 1'b0;
            end
            if (st_mark) begin
                wr_q[si] <= 1'b1;
                if (st_alloc) rd_q[si] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ld_alloc && !clr_all) tag_q[li] <= ld_tag;
        if (st_alloc && !clr_all) tag_q[si] <= st_tag;
    end

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_snp
            always_comb begin
                snp_rd[w]                   = rd_q[{snp_set, WAY_W'(w)}];
                snp_tag[w*TAG_W +: TAG_W]   = tag_q[{snp_set, WAY_W'(w)}];
            end
        end
    endgenerate
endmodule

// File: rtl/srt_snoop_match.sv
`timescale 1ns/1ps
module srt_snoop_match #(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 20,
    parameter int RANK_W = 2
) (
    input  logic                  bw_v,
    input  logic [TAG_W-1:0]      bw_tag,
    input  logic [RANK_W-1:0]     bw_rank,
    input  logic [RANK_W-1:0]     my_rank,
    input  logic [WAYS-1:0]       way_rd,
    input  logic [WAYS*TAG_W-1:0] way_tag,
    output logic                  hit
);
    logic [WAYS-1:0] way_m;
    logic earlier;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign way_m[w] = way_rd[w] && (way_tag[w*TAG_W +: TAG_W] == bw_tag);
        end
    endgenerate

    // only sequentially earlier writers can break this thread's reads
    assign earlier = (bw_rank < my_rank);
    assign hit     = bw_v && earlier && (|way_m);
endmodule

// File: rtl/srt_ctrl.sv
`timescale 1ns/1ps
module srt_ctrl
    import srt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_any,
    input  logic head,
    input  logic snoop_hit,
    input  logic conflict,
    output logic upd_en,
    output logic viol,
    output logic ovf
);
    trk_state_e state_q, state_d;
    logic hit_eff, conf_eff;

    always_comb begin
        upd_en   = (state_q == ST_TRACK) && !clr_any;
        hit_eff  = snoop_hit && !clr_any &&
                   ((state_q == ST_TRACK) || (state_q == ST_STALL));
        conf_eff = conflict && upd_en;
    end

    always_comb begin
        state_d = state_q;
        if (clr_any) begin
            state_d = head ? ST_HEAD : ST_TRACK;
        end else begin
            unique case (state_q)
                ST_HEAD:  if (!head) state_d = ST_TRACK;
                ST_TRACK: begin
                    if (hit_eff)       state_d = ST_VIOL;
                    else if (conf_eff) state_d = ST_STALL;
                    else if (head)     state_d = ST_HEAD;
                end
                ST_STALL: begin
                    if (hit_eff)   state_d = ST_VIOL;
                    else if (head) state_d = ST_HEAD;
                end
                ST_VIOL:  state_d = ST_VIOL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            viol <= hit_eff;
            ovf  <= (state_d == ST_STALL);
        end
    end
endmodule

// File: rtl/srt_violation_detector.sv
`timescale 1ns/1ps
module srt_violation_detector #(
    parameter int SETS   = 128,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 20,
    parameter int RANK_W = 2,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [RANK_W-1:0]      i_my_rank,
    input  logic                   i_head,
    input  logic                   i_ld_valid,
    input  logic [SET_W-1:0]       i_ld_set,
    input  logic [WAY_W-1:0]       i_ld_way,
    input  logic [TAG_W-1:0]       i_ld_tag,
    input  logic                   i_st_valid,
    input  logic [SET_W-1:0]       i_st_set,
    input  logic [WAY_W-1:0]       i_st_way,
    input  logic [TAG_W-1:0]       i_st_tag,
    input  logic                   i_bw_valid,
    input  logic [TAG_W+SET_W-1:0] i_bw_line,
    input  logic [RANK_W-1:0]      i_bw_rank,
    input  logic                   i_clr_commit,
    input  logic                   i_clr_restart,
    output logic                   o_violation,
    output logic                   o_overflow
);
    logic                  clr_any, upd_en, conflict, snoop_hit;
    logic [SET_W-1:0]      bw_set;
    logic [TAG_W-1:0]      bw_tag;
    logic [WAYS-1:0]       snp_rd;
    logic [WAYS*TAG_W-1:0] snp_tag;

    assign clr_any = i_clr_commit || i_clr_restart;
    assign bw_set  = i_bw_line[SET_W-1:0];
    assign bw_tag  = i_bw_line[SET_W +: TAG_W];

    srt_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_any), .upd_en(upd_en),
        .ld_v(i_ld_valid), .ld_set(i_ld_set), .ld_way(i_ld_way), .ld_tag(i_ld_tag),
        .st_v(i_st_valid), .st_set(i_st_set), .st_way(i_st_way), .st_tag(i_st_tag),
        .snp_set(bw_set), .conflict(conflict), .snp_rd(snp_rd), .snp_tag(snp_tag)
    );

    srt_snoop_match #(.WAYS(WAYS), .TAG_W(TAG_W), .RANK_W(RANK_W)) u_snp (
        .bw_v(i_bw_valid), .bw_tag(bw_tag), .bw_rank(i_bw_rank),
        .my_rank(i_my_rank), .way_rd(snp_rd), .way_tag(snp_tag), .hit(snoop_hit)
    );

    srt_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr_any(clr_any), .head(i_head),
        .snoop_hit(snoop_hit), .conflict(conflict), .upd_en(upd_en),
        .viol(o_violation), .ovf(o_overflow)
    );
endmodule

// File: rtl/srt_checker.sv
`timescale 1ns/1ps
module srt_checker #(
    parameter int RANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RANK_W-1:0] i_my_rank,
    input logic              i_head,
    input logic              i_bw_valid,
    input logic [RANK_W-1:0] i_bw_rank,
    input logic              i_clr_commit,
    input logic              i_clr_restart,
    input logic              o_violation,
    input logic              o_overflow
);
    p_needs_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        o_violation |-> $past(i_bw_valid));

    p_earlier_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        o_violation |-> $past(i_bw_rank < i_my_rank));

    p_head_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(i_head) && $past(i_head, 2)) |-> !o_violation);

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(i_clr_commit || i_clr_restart) |-> !o_violation);

    p_ovf_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_overflow && i_head) |=> !o_overflow);

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        o_violation |=> !o_violation);
endmodule

bind srt_violation_detector srt_checker #(.RANK_W(RANK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .i_my_rank(i_my_rank), .i_head(i_head),
    .i_bw_valid(i_bw_valid), .i_bw_rank(i_bw_rank),
    .i_clr_commit(i_clr_commit), .i_clr_restart(i_clr_restart),
    .o_violation(o_violation), .o_overflow(o_overflow)
);

// File: tb/sim_srt_violation_detector.sv
`timescale 1ns/1ps
module sim_srt_violation_detector;
    localparam int SETS = 128, WAYS = 4, TAG_W = 20, RANK_W = 2;
    localparam int SET_W = $clog2(SETS), WAY_W = $clog2(WAYS);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [RANK_W-1:0] my_rank = 2'd2;
    logic head = 1'b0;
    logic ld_v = 1'b0, st_v = 1'b0, bw_v = 1'b0;
    logic [SET_W-1:0] ld_set = '0, st_set = '0;
    logic [WAY_W-1:0] ld_way = '0, st_way = '0;
    logic [TAG_W-1:0] ld_tag = '0, st_tag = '0;
    logic [TAG_W+SET_W-1:0] bw_line = '0;
    logic [RANK_W-1:0] bw_rank = '0;
    logic clr_c = 1'b0, clr_r = 1'b0;
    logic viol, ovf;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    srt_violation_detector #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .RANK_W(RANK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .i_my_rank(my_rank), .i_head(head),
        .i_ld_valid(ld_v), .i_ld_set(ld_set), .i_ld_way(ld_way), .i_ld_tag(ld_tag),
        .i_st_valid(st_v), .i_st_set(st_set), .i_st_way(st_way), .i_st_tag(st_tag),
        .i_bw_valid(bw_v), .i_bw_line(bw_line), .i_bw_rank(bw_rank),
        .i_clr_commit(clr_c), .i_clr_restart(clr_r),
        .o_violation(viol), .o_overflow(ovf)
    );

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        ld_v = 0; st_v = 0; bw_v = 0; clr_c = 0; clr_r = 0;
    endtask

    task automatic do_load(int s, int w, int t);
        ld_v = 1; ld_set = SET_W'(s); ld_way = WAY_W'(w); ld_tag = TAG_W'(t);
        step(); quiet();
    endtask

    task automatic do_store(int s, int w, int t);
        st_v = 1; st_set = SET_W'(s); st_way = WAY_W'(w); st_tag = TAG_W'(t);
        step(); quiet();
    endtask

    // drives a bus store; o_violation is registered on this edge, sample right after
    task automatic do_bus(int s, int t, int r);
        bw_v = 1; bw_line = {TAG_W'(t), SET_W'(s)}; bw_rank = RANK_W'(r);
        step(); quiet();
    endtask

    task automatic do_clear(bit restart);
        if (restart) clr_r = 1; else clr_c = 1;
        step(); quiet();
    endtask

    task automatic t_reset();
        check("R1 violation at reset", viol, 1'b0);
        check("R1 overflow at reset", ovf, 1'b0);
        do_bus(5, 'h111, 0);
        check("R1 no tags after reset", viol, 1'b0);
    endtask

    task automatic t_basic();
        do_load(5, 1, 'hA);
        do_bus(5, 'hA, 1);
        check("R2 earlier store after read", viol, 1'b1);
        step();
        check("R2 pulse lasts one cycle", viol, 1'b0);
        do_clear(1);
    endtask

    task automatic t_late_rank();
        do_load(5, 1, 'hA);
        do_bus(5, 'hA, 3);
        check("R3 later rank ignored", viol, 1'b0);
        do_bus(5, 'hA, 2);
        check("R3 equal rank ignored", viol, 1'b0);
        do_bus(5, 'hA, 0);
        check("R3 flag still set", viol, 1'b1);
        do_clear(1);
    endtask

    task automatic t_miss();
        do_load(5, 1, 'hA);
        do_bus(5, 'hB, 0);
        check("R4 other tag same set", viol, 1'b0);
        do_bus(6, 'hA, 0);
        check("R4 same tag other set", viol, 1'b0);
        do_clear(0);
    endtask

    task automatic t_local();
        do_store(9, 0, 'hC);
        do_load(9, 0, 'hC);
        do_bus(9, 'hC, 1);
        check("R5 load of own store not flagged", viol, 1'b0);
        do_clear(0);
    endtask

    task automatic t_head();
        head = 1; step();
        do_load(12, 2, 'h5);
        do_bus(12, 'h5, 0);
        check("R6 snoop ignored as head", viol, 1'b0);
        head = 0; step();
        do_bus(12, 'h5, 0);
        check("R6 head load left no flag", viol, 1'b0);
    endtask

    task automatic t_clear();
        do_load(20, 3, 'h77);
        do_clear(0);
        do_bus(20, 'h77, 0);
        check("R7 commit clears flags", viol, 1'b0);
        do_load(20, 3, 'h77);
        clr_r = 1; bw_v = 1; bw_line = {TAG_W'('h77), SET_W'(20)}; bw_rank = 0;
        step(); quiet();
        check("R7 clear beats same-cycle store", viol, 1'b0);
        do_bus(20, 'h77, 0);
        check("R7 restart clears flags", viol, 1'b0);
    endtask

    task automatic t_overflow();
        do_load(3, 2, 'hD);
        do_load(3, 2, 'hE);
        check("R8 overflow raised", ovf, 1'b1);
        step(); step();
        check("R8 overflow held", ovf, 1'b1);
        do_bus(3, 'hE, 0);
        check("R8 conflicting line untracked", viol, 1'b0);
        do_bus(3, 'hD, 0);
        check("R8 original line still tracked", viol, 1'b1);
        do_clear(1);
        check("R8 overflow cleared by restart", ovf, 1'b0);
        do_load(3, 2, 'hD);
        do_load(3, 2, 'hE);
        check("R8 overflow raised again", ovf, 1'b1);
        head = 1; step();
        check("R8 overflow drops at head", ovf, 1'b0);
        head = 0; step();
        do_clear(0);
    endtask

    task automatic t_viol_hold();
        do_load(40, 0, 'h1);
        do_load(41, 0, 'h2);
        do_bus(40, 'h1, 1);
        check("R9 first violation", viol, 1'b1);
        do_bus(41, 'h2, 1);
        check("R9 no second pulse", viol, 1'b0);
        do_clear(1);
        do_load(40, 0, 'h1);
        do_bus(40, 'h1, 1);
        check("R9 tracking resumes after restart", viol, 1'b1);
        do_clear(1);
    endtask

    task automatic t_ways();
        do_load(7, 0, 'h10);
        do_load(7, 3, 'h13);
        do_bus(7, 'h13, 0);
        check("R10 way 3 flagged", viol, 1'b1);
        do_clear(1);
        do_load(7, 0, 'h10);
        do_bus(7, 'h13, 0);
        check("R10 way 3 not flagged by way 0 load", viol, 1'b0);
        do_bus(7, 'h10, 0);
        check("R10 way 0 flagged", viol, 1'b1);
        do_clear(1);
    endtask

    initial begin
        quiet();
        step(); step();
        rst_n = 1;
        step();
        t_reset();
        t_basic();
        t_late_rank();
        t_miss();
        t_local();
        t_head();
        t_clear();
        t_overflow();
        t_viol_hold();
        t_ways();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule